// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block produces the oversampling enable for one serial channel from a reference clock. The enable is a single-cycle pulse in the reference clock domain, not a derived clock. A divide-by-1 or divide-by-4 prescaler comes first. A divisor stage follows it. The divisor has a 16-bit integer part, supplied as a low byte and a high byte, and a 4-bit fraction counted in sixteenths. The fraction is realized by lengthening some tick intervals by one prescaler-output cycle. A 4-bit phase accumulator adds the fraction code on every tick and stretches the next interval whenever it carries out. This spreads the longer intervals as evenly as possible.

A second output marks bit boundaries: it coincides with every 16th, 8th or 4th sample tick, depending on the oversampling select. The host register file, shift registers and FIFOs sit outside the block. The block only watches the divisor and prescaler inputs: any change to them restarts its counters, so that a new rate begins cleanly.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst_n` is low, both `sample_tick` and `bit_tick` are 0. With the power-on divisor (low byte 0x01, high byte 0x00, fraction 0x0, prescaler off) held steady, `sample_tick` is 1 in every cycle.
- R2: With fraction 0 and prescaler off, sample ticks are N cycles apart, where N = 256*high + low. An integer value of 0 is used as 1, so the output never stalls.
- R3: With `prescale_sel` = 1, every interval is four times its length with `prescale_sel` = 0. Two sample ticks are therefore never in adjacent cycles.
- R4: With fraction code F (0..15), prescale factor P (1 or 4) and effective integer N, the k-th sample tick after a restart occurs in cycle P*(k*N + floor((k-1)*F/16)). Cycle 1 is the first cycle after the restarting edge. As a result, exactly F of any 16 consecutive intervals are one prescaler cycle longer than the rest.
- R5: `os_mode` selects the bit-tick ratio: 2'b00 gives 16, 2'b01 gives 8, 2'b10 gives 4, and 2'b11 gives 16. `bit_tick` is 1 exactly on sample ticks whose index after a restart is a multiple of that ratio.
- R6: In 8X mode with an odd fraction, successive bit intervals differ by one prescaler cycle. Each lasts P*(8N + floor(F/2)) or P*(8N + ceil(F/2)), and any two consecutive intervals total P*(16N + F).
- R7: A change on `div_lo`, `div_hi`, `div_frac` or `prescale_sel` restarts all counters at the next rising edge. `sample_tick` is 0 in the cycle in which the changed value is first presented. The first tick after the change comes one full new interval later.
- R8: `bit_tick` is never 1 unless `sample_tick` is 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prescale_sel | input | 1 | 0: prescaler divides by 1, 1: divides by 4 |
| div_lo | input | 8 | Integer divisor, low byte |
| div_hi | input | 8 | Integer divisor, high byte |
| div_frac | input | 4 | Fractional divisor in sixteenths |
| os_mode | input | 2 | Oversampling ratio select (R5 encoding) |
| sample_tick | output | 1 | One-cycle oversampling enable |
| bit_tick | output | 1 | One-cycle bit boundary enable |

## Verification
The bench builds the block with its default parameters: a 16-bit integer divisor, a 4-bit fraction, a prescale factor of 4 and a 16X maximum ratio. These defaults put every fraction code and all four mode codes within reach. They also cover both prescaler settings, and integer values whose high byte is nonzero, so that the byte concatenation is exercised. Small random integer parts keep each run short, so dozens of tick intervals per setting fit in the cycle budget. Directed settings cover the zero divisor, the 256 divisor and the 8X odd-fraction jitter.

// File: rtl/fbg_pkg.sv
// Shared definitions for the fractional baud rate generator.
// Assumes the oversampling select is two bits wide; code 3 aliases 16X.
package fbg_pkg;
    localparam int FBG_INT_W   = 16;
    localparam int FBG_FRAC_W  = 4;
    localparam int FBG_PRE_DIV = 4;
    localparam int FBG_OS_LOG  = 4;

    typedef enum logic [1:0] {
        OS_X16 = 2'b00,
        OS_X8  = 2'b01,
        OS_X4  = 2'b10,
        OS_ALT = 2'b11
    } os_mode_e;
endpackage

// File: rtl/fbg_prescaler.sv
// Prescaler: emits a step enable every cycle, or once every PRE_DIV cycles
// when sel is high. Assumes PRE_DIV >= 2; restart realigns the phase.
module fbg_prescaler #(
    parameter int PRE_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic sel,
    output logic step
);
    localparam int PW = $clog2(PRE_DIV);
    localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

    logic [PW-1:0] phase;

    // Free-running phase counter, cleared on reset or restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // Step enable: always on when bypassed, else once per wrap
    always_comb begin
        step = sel ? (phase == LAST) : 1'b1;
    end
endmodule

// File: rtl/fbg_frac_div.sv
// Fractional divider: counts prescaler steps and emits a tick every N steps,
// plus one extra step on intervals selected by a phase accumulator carry.
// Assumes an integer value of 0 means 1.
module fbg_frac_div #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic [INT_W-1:0]  int_div,
    input  logic [FRAC_W-1:0] frac,
    output logic              tick
);
    logic [INT_W-1:0]  cnt;
    logic [FRAC_W-1:0] phase_acc;
    logic              stretch;
    logic [INT_W:0]    n_eff;
    logic [INT_W:0]    last_idx;
    logic              at_end;
    logic [FRAC_W:0]   acc_sum;

    // Effective interval end, including the optional stretch step
    always_comb begin
        n_eff    = (int_div == '0) ? (INT_W+1)'(1) : {1'b0, int_div};
        last_idx = n_eff - (INT_W+1)'(1) + (INT_W+1)'(stretch);
        at_end   = ({1'b0, cnt} == last_idx);
        acc_sum  = {1'b0, phase_acc} + {1'b0, frac};
        tick     = step && at_end && !restart;
    end

    // Step counter and fraction accumulator
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt       <= '0;
            phase_acc <= '0;
            stretch   <= 1'b0;
        end else if (step) begin
            if (at_end) begin
                cnt       <= '0;
                phase_acc <= acc_sum[FRAC_W-1:0];
                stretch   <= acc_sum[FRAC_W];
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fbg_os_count.sv
// Oversampling counter: counts sample ticks and flags those that close a
// bit period of 2**OS_LOG, 2**(OS_LOG-1) or 2**(OS_LOG-2) ticks.
// Assumes OS_LOG >= 2.
module fbg_os_count #(
    parameter int OS_LOG = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        tick,
    input  logic [1:0]  mode,
    output logic        bit_tick
);
    import fbg_pkg::*;

    localparam logic [OS_LOG-1:0] MASK_FULL = {OS_LOG{1'b1}};
    localparam logic [OS_LOG-1:0] MASK_HALF = MASK_FULL >> 1;
    localparam logic [OS_LOG-1:0] MASK_QTR  = MASK_FULL >> 2;

    logic [OS_LOG-1:0] tcnt;
    logic [OS_LOG-1:0] mask;

    // Select the wrap mask from the oversampling code
    always_comb begin
        case (os_mode_e'(mode))
            OS_X8:   mask = MASK_HALF;
            OS_X4:   mask = MASK_QTR;
            default: mask = MASK_FULL;
        endcase
        bit_tick = tick && ((tcnt & mask) == mask);
    end

    // Sample-tick counter, cleared on reset or restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            tcnt <= '0;
        end else if (tick) begin
            tcnt <= tcnt + 1'b1;
        end
    end
endmodule

// File: rtl/frac_baud_gen.sv
// Fractional baud rate generator top. Watches the divisor and prescaler
// inputs, restarts the counters when any of them changes, and drives the
// sample and bit enables. Assumes the inputs are synchronous to clk.
module frac_baud_gen #(
    parameter int INT_W   = fbg_pkg::FBG_INT_W,
    parameter int FRAC_W  = fbg_pkg::FBG_FRAC_W,
    parameter int PRE_DIV = fbg_pkg::FBG_PRE_DIV,
    parameter int OS_LOG  = fbg_pkg::FBG_OS_LOG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prescale_sel,
    input  logic [INT_W/2-1:0] div_lo,
    input  logic [INT_W/2-1:0] div_hi,
    input  logic [FRAC_W-1:0] div_frac,
    input  logic [1:0]        os_mode,
    output logic              sample_tick,
    output logic              bit_tick
);
    localparam int CFG_W = INT_W + FRAC_W + 1;

    logic [CFG_W-1:0] cfg_now;
    logic [CFG_W-1:0] cfg_q;
    logic             restart;
    logic             step;
    logic             raw_tick;

    // Current divisor configuration as one vector
    always_comb begin
        cfg_now     = {prescale_sel, div_hi, div_lo, div_frac};
        restart     = rst_n && (cfg_now != cfg_q);
        sample_tick = rst_n && raw_tick;
    end

    // Remember last cycle's configuration, also during reset
    always_ff @(posedge clk) begin
        cfg_q <= cfg_now;
    end

    fbg_prescaler #(.PRE_DIV(PRE_DIV)) i_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .sel     (prescale_sel),
        .step    (step)
    );

    fbg_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .step    (step),
        .int_div ({div_hi, div_lo}),
        .frac    (div_frac),
        .tick    (raw_tick)
    );

    fbg_os_count #(.OS_LOG(OS_LOG)) i_os (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .tick     (sample_tick),
        .mode     (os_mode),
        .bit_tick (bit_tick)
    );
endmodule

// File: rtl/fbg_checker.sv
// Property checker for frac_baud_gen, attached by bind.
// Assumes default widths of the top's divisor ports.
module fbg_checker #(
    parameter int INT_W  = fbg_pkg::FBG_INT_W,
    parameter int FRAC_W = fbg_pkg::FBG_FRAC_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               prescale_sel,
    input logic [INT_W/2-1:0] div_lo,
    input logic [INT_W/2-1:0] div_hi,
    input logic [FRAC_W-1:0]  div_frac,
    input logic [1:0]         os_mode,
    input logic               sample_tick,
    input logic               bit_tick
);
    logic [INT_W+FRAC_W:0] cfg;
    logic                  is_unit;

    // Configuration vector and unit-divisor detection
    always_comb begin
        cfg     = {prescale_sel, div_hi, div_lo, div_frac};
        is_unit = !prescale_sel && (div_hi == '0) && (div_lo <= 1) && (div_frac == '0);
    end

    // R8
    tick_pairing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick);

    // R1
    unit_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_unit && $stable(cfg)) |-> sample_tick);

    // R3
    presc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick && prescale_sel) |=> !sample_tick);

    // R7
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> !sample_tick);

    // R5
    x4_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && os_mode == 2'b10 && $stable(os_mode)) |=> !bit_tick);
endmodule

bind frac_baud_gen fbg_checker #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_fbg_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .prescale_sel (prescale_sel),
    .div_lo       (div_lo),
    .div_hi       (div_hi),
    .div_frac     (div_frac),
    .os_mode      (os_mode),
    .sample_tick  (sample_tick),
    .bit_tick     (bit_tick)
);

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prescale_sel = 1'b0;
    logic [7:0] div_lo = 8'h01;
    logic [7:0] div_hi = 8'h00;
    logic [3:0] div_frac = 4'h0;
    logic [1:0] os_mode = 2'b00;
    logic       sample_tick;
    logic       bit_tick;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int bt_time [0:15];
    int bt_n;

    always #2.5 clk = ~clk;

    frac_baud_gen i_frac_baud_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .prescale_sel (prescale_sel),
        .div_lo       (div_lo),
        .div_hi       (div_hi),
        .div_frac     (div_frac),
        .os_mode      (os_mode),
        .sample_tick  (sample_tick),
        .bit_tick     (bit_tick)
    );

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 180000) begin
            fails = fails + 1;
            $display("FAIL watchdog (all reqs) actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic int exp_time(int k, int n, int f, int p);
        return p * (k * n + ((k - 1) * f) / 16);
    endfunction

    function automatic int ratio(logic [1:0] m);
        return (m == 2'b01) ? 8 : (m == 2'b10) ? 4 : 16;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply a configuration (forcing a restart) and check K tick times
    task automatic run_cfg(input bit p, input logic [15:0] d, input logic [3:0] f,
                           input logic [1:0] m, input int k_max, input string req);
        int n;
        int pf;
        int mr;
        int idx;
        int bad_c;
        int bad_e;
        bit ok;
        n  = (d == 16'd0) ? 1 : int'(d);
        pf = p ? 4 : 1;
        mr = ratio(m);
        @(negedge clk);
        div_lo = ~d[7:0];
        @(negedge clk);
        prescale_sel = p;
        div_lo = d[7:0];
        div_hi = d[15:8];
        div_frac = f;
        os_mode = m;
        #1;
        // R7: no tick in the cycle the new value appears
        check(!sample_tick, "R7 quiet on change", int'(sample_tick), 0);
        @(posedge clk);
        idx = 0;
        ok = 1'b1;
        bad_c = 0;
        bad_e = 0;
        bt_n = 0;
        for (int c = 1; c <= exp_time(k_max, n, int'(f), pf) + 2 && idx < k_max; c++) begin
            @(negedge clk);
            if (bit_tick && !sample_tick && ok) begin
                ok = 1'b0; bad_c = c; bad_e = -1;   // R8
            end
            if (sample_tick) begin
                idx++;
                if (ok && c != exp_time(idx, n, int'(f), pf)) begin
                    ok = 1'b0; bad_c = c; bad_e = exp_time(idx, n, int'(f), pf);
                end
                if (ok && bit_tick != ((idx % mr) == 0)) begin
                    ok = 1'b0; bad_c = int'(bit_tick); bad_e = int'((idx % mr) == 0);
                end
                if (bit_tick && bt_n < 16) begin
                    bt_time[bt_n] = c;
                    bt_n++;
                end
            end
        end
        if (idx != k_max && ok) begin
            ok = 1'b0; bad_c = idx; bad_e = k_max;
        end
        check(ok, req, bad_c, bad_e);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: outputs held low during reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!sample_tick && !bit_tick, "R1 reset quiet", int'(sample_tick), 0);
        end
        rst_n = 1'b1;
        @(posedge clk);
        // R1: power-on divisor gives a tick in every cycle
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(sample_tick, "R1 unit divisor", int'(sample_tick), 1);
        end

        // R2: integer divisors, zero treated as one, high byte used
        run_cfg(1'b0, 16'd0,   4'd0, 2'b00, 20, "R2 zero divisor");
        run_cfg(1'b0, 16'd7,   4'd0, 2'b00, 34, "R2 integer 7");
        run_cfg(1'b0, 16'h0100, 4'd0, 2'b10, 5, "R2 high byte");
        // R3: prescaler
        run_cfg(1'b1, 16'd3,   4'd0, 2'b00, 20, "R3 prescale x4");
        run_cfg(1'b1, 16'd1,   4'd0, 2'b10, 12, "R3 prescale unit");
        // R4: fraction extremes
        run_cfg(1'b0, 16'd2,   4'd15, 2'b00, 34, "R4 fraction 15");
        run_cfg(1'b0, 16'd0,   4'd8,  2'b00, 34, "R4 zero int fraction 8");
        // R5: every mode code, including the alias
        run_cfg(1'b0, 16'd2,   4'd1,  2'b11, 34, "R5 mode 11 as 16X");
        run_cfg(1'b0, 16'd3,   4'd5,  2'b01, 34, "R5 mode 8X");

        // R6: 8X with odd fraction, bit-interval jitter
        run_cfg(1'b0, 16'd5,   4'd3,  2'b01, 40, "R6 8X odd fraction");
        for (int i = 1; i + 1 < bt_n; i++) begin
            int a;
            int b;
            a = bt_time[i] - bt_time[i-1];
            b = bt_time[i+1] - bt_time[i];
            check((a == 41 || a == 42) && (a + b == 83), "R6 8X jitter", a + b, 83);
        end

        // R4 R5 R7: constrained random configurations
        for (int i = 0; i < 24; i++) begin
            logic [15:0] d;
            d = 16'($urandom_range(0, 12));
            run_cfg(1'($urandom_range(0, 1)), d, 4'($urandom_range(0, 15)),
                    2'($urandom_range(0, 3)), 34, "R4 random config");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule